// File: doc/BRIEF.md
# Two-Level Queued Interrupt Aggregator

This block gathers interrupt events from two levels. A secondary unit records many event sources in its own identity register. A primary unit records a small set of sources plus one cascade bit that tracks the secondary unit. The primary unit drives a single CPU interrupt line. Every identity bit holds one visible event and can keep one further event queued behind it. When software clears a visible bit that has a queued event, the bit sets itself again after a one-cycle gap.

The secondary unit reports to the primary unit through a summary signal. The cascade bit is set only when that summary rises, never by its level. While the summary stays high, new secondary events give no further cascade. Software has two ways to signal the CPU again: drain the secondary unit until the summary falls, or pull the secondary enable register to zero and then restore it. A master bit in the primary enable register gates the CPU line.

Software reaches four registers through a simple read/write port with one cycle of read latency. The two identity registers are write-one-to-clear. The event sources are single-cycle input pulses.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all four registers read zero, every queue slot is empty and `cpu_irq_o` is low.
- R2: An event pulse on a source sets its visible identity bit at the next clock edge. This happens even when the bit is disabled in its enable register.
- R3: An event that arrives while a bit is visible and its queue slot is empty fills the slot. An event that arrives while the bit and its slot are both occupied is dropped.
- R4: After a write-one-to-clear of a visible bit whose slot is full, the bit reads 0 for one cycle. It is then set again and the slot empties.
- R5: A clear and a new event on the same bit in the same cycle leave the bit set. The queue slot is left unchanged.
- R6: The secondary summary is the OR over all secondary bits of ((visible OR queued) AND enable). The primary cascade bit (index `CASCADE_IDX`, default 3) is set at the clock edge after the summary rises.
- R7: While the secondary summary stays high, further secondary events never set the cascade bit again. This holds after software has cleared the cascade bit too.
- R8: Writing zero to the secondary enable register forces the summary low. Restoring the enable while secondary bits are pending makes the summary rise, and that sets the cascade bit.
- R9: When the master bit (bit `MASTER_IDX`, default 31, of the primary enable register) is 0, `cpu_irq_o` is low whatever identity bits are set.
- R10: `cpu_irq_o` equals master AND the OR over primary bits of ((visible OR queued) AND primary enable).
- R11: The register map uses byte offsets 0x0 for primary identity, 0x4 for primary enable, 0x8 for secondary identity and 0xC for secondary enable. Identity reads return the visible bits. A read returns the register contents from before the clock edge at which `reg_rd_i` is sampled, and the data appears on `reg_rdata_o` just after that edge.
- R12: Primary external event bits follow the same queueing, refill and write-one-to-clear rules as the secondary bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sec_evt_i | input | NUM_SEC | Secondary event pulses |
| pri_evt_i | input | NUM_PRI | Primary event pulses (ORed into the cascade bit at its index) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| cpu_irq_o | output | 1 | CPU interrupt line |

## Verification
An event sets its identity bit at the edge that samples it, so a read issued in the following cycle returns it. A secondary event reaches the cascade bit one edge later, because the summary must first be captured by the edge detector. The first read after the event therefore still shows the cascade bit clear, and only the second read shows it set; the bench checks both reads. After a clear of a bit with a queued event, the bench expects the bit to read 0 on the first read and 1 on the next. The CPU line is a direct function of the registers, so the bench samples it one time unit after each edge and compares it with a cycle model that advances on the same edge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 4;

   typedef enum logic [1:0] {
      SEL_PID = 2'd0,
      SEL_PEN = 2'd1,
      SEL_SID = 2'd2,
      SEL_SEN = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_ident_array.sv
module irq_ident_array #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] evt_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] vis_o,
   output logic [WIDTH-1:0] pend_o
);
   logic [WIDTH-1:0] vis_q, que_q, vis_d, que_d;

   function automatic logic [1:0] slot_next(input logic v, input logic q,
                                            input logic e, input logic c);
      logic vn, qn;
      vn = v;
      qn = q;
      if (!v) begin
         if (q) begin
            vn = 1'b1;
            qn = e;
         end else begin
            vn = e;
         end
      end else if (c) begin
         vn = e;
      end else if (e) begin
         qn = 1'b1;
      end
      return {vn, qn};
   endfunction

   for (genvar b = 0; b < WIDTH; b++) begin : g_slot
      assign {vis_d[b], que_d[b]} = slot_next(vis_q[b], que_q[b], evt_i[b], clr_i[b]);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         vis_q <= '0;
         que_q <= '0;
      end else begin
         vis_q <= vis_d;
         que_q <= que_d;
      end
   end

   assign vis_o  = vis_q;
   assign pend_o = vis_q | que_q;

   assert_event_lands_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (|evt_i) |=> ((vis_q & $past(evt_i)) == $past(evt_i)));

   assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (|(vis_q & que_q & evt_i & ~clr_i)) |=>
      ((vis_q & que_q & $past(vis_q & que_q & evt_i & ~clr_i))
       == $past(vis_q & que_q & evt_i & ~clr_i)));

   assert_refill_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (|(~vis_q & que_q)) |=>
      ((vis_q & $past(~vis_q & que_q)) == $past(~vis_q & que_q)));
endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;

   assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_cascade_pkg::*;
#(
   parameter int unsigned NUM_PRI    = 8,
   parameter int unsigned NUM_SEC    = 16,
   parameter int unsigned MASTER_IDX = 31
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               wr_i,
   input  logic               rd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [NUM_PRI-1:0] pri_vis_i,
   input  logic [NUM_SEC-1:0] sec_vis_i,
   output logic [NUM_PRI-1:0] pri_en_o,
   output logic               pri_master_o,
   output logic [NUM_SEC-1:0] sec_en_o,
   output logic [NUM_PRI-1:0] pri_clr_o,
   output logic [NUM_SEC-1:0] sec_clr_o,
   output logic [REG_W-1:0]   rdata_o
);
   reg_sel_e sel;
   logic [NUM_PRI-1:0] pen_q;
   logic               master_q;
   logic [NUM_SEC-1:0] sen_q;
   logic [REG_W-1:0]   pid_w, pen_w, sid_w, sen_w, rd_mux, rdata_q;
   logic               unused_bits;

   assign sel         = reg_sel_e'(addr_i[ADDR_W-1:2]);
   assign unused_bits = ^{wdata_i, addr_i[1:0]};

   assign pri_clr_o = (wr_i && sel == SEL_PID) ? wdata_i[NUM_PRI-1:0] : '0;
   assign sec_clr_o = (wr_i && sel == SEL_SID) ? wdata_i[NUM_SEC-1:0] : '0;

   always_comb begin
      pid_w = '0;
      pen_w = '0;
      sid_w = '0;
      sen_w = '0;
      pid_w[NUM_PRI-1:0] = pri_vis_i;
      pen_w[NUM_PRI-1:0] = pen_q;
      pen_w[MASTER_IDX]  = master_q;
      sid_w[NUM_SEC-1:0] = sec_vis_i;
      sen_w[NUM_SEC-1:0] = sen_q;
      unique case (sel)
         SEL_PID: rd_mux = pid_w;
         SEL_PEN: rd_mux = pen_w;
         SEL_SID: rd_mux = sid_w;
         default: rd_mux = sen_w;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pen_q    <= '0;
         master_q <= 1'b0;
         sen_q    <= '0;
         rdata_q  <= '0;
      end else begin
         if (wr_i && sel == SEL_PEN) begin
            pen_q    <= wdata_i[NUM_PRI-1:0];
            master_q <= wdata_i[MASTER_IDX];
         end
         if (wr_i && sel == SEL_SEN) sen_q <= wdata_i[NUM_SEC-1:0];
         if (rd_i) rdata_q <= rd_mux;
      end
   end

   assign pri_en_o     = pen_q;
   assign pri_master_o = master_q;
   assign sec_en_o     = sen_q;
   assign rdata_o      = rdata_q;

   assert_read_latency_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_i && sel == SEL_SID) |=> (rdata_o == $past(sid_w)));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irq_cascade_pkg::*;
#(
   parameter int unsigned NUM_SEC     = 16,
   parameter int unsigned NUM_PRI     = 8,
   parameter int unsigned CASCADE_IDX = 3,
   parameter int unsigned MASTER_IDX  = 31
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SEC-1:0] sec_evt_i,
   input  logic [NUM_PRI-1:0] pri_evt_i,
   input  logic               reg_wr_i,
   input  logic               reg_rd_i,
   input  logic [3:0]         reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               cpu_irq_o
);
   if (NUM_SEC < 1 || NUM_SEC > REG_W) begin : g_bad_sec
      $error("NUM_SEC must lie in 1..32");
   end
   if (NUM_PRI < 1 || NUM_PRI >= REG_W) begin : g_bad_pri
      $error("NUM_PRI must lie in 1..31");
   end
   if (CASCADE_IDX >= NUM_PRI) begin : g_bad_casc
      $error("CASCADE_IDX must address a primary bit");
   end
   if (MASTER_IDX < NUM_PRI || MASTER_IDX >= REG_W) begin : g_bad_master
      $error("MASTER_IDX must lie above the primary bits");
   end

   logic [NUM_SEC-1:0] s_vis, s_pend, s_en, s_clr;
   logic [NUM_PRI-1:0] p_vis, p_pend, p_en, p_clr, p_evt;
   logic               p_master, sec_sum, cas_rise;

   irq_reg_port #(
      .NUM_PRI(NUM_PRI), .NUM_SEC(NUM_SEC), .MASTER_IDX(MASTER_IDX)
   ) u_port (
      .clk_i(clk_i), .rst_i(rst_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
      .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .pri_vis_i(p_vis), .sec_vis_i(s_vis),
      .pri_en_o(p_en), .pri_master_o(p_master), .sec_en_o(s_en),
      .pri_clr_o(p_clr), .sec_clr_o(s_clr), .rdata_o(reg_rdata_o)
   );

   irq_ident_array #(.WIDTH(NUM_SEC)) u_sec (
      .clk_i(clk_i), .rst_i(rst_i), .evt_i(sec_evt_i), .clr_i(s_clr),
      .vis_o(s_vis), .pend_o(s_pend)
   );

   assign sec_sum = |(s_pend & s_en);

   irq_rise_detect u_edge (
      .clk_i(clk_i), .rst_i(rst_i), .level_i(sec_sum), .rise_o(cas_rise)
   );

   assign p_evt = pri_evt_i | (NUM_PRI'(cas_rise) << CASCADE_IDX);

   irq_ident_array #(.WIDTH(NUM_PRI)) u_pri (
      .clk_i(clk_i), .rst_i(rst_i), .evt_i(p_evt), .clr_i(p_clr),
      .vis_o(p_vis), .pend_o(p_pend)
   );

   assign cpu_irq_o = p_master & (|(p_pend & p_en));

   assert_cascade_rise_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sec_sum) |=> p_vis[CASCADE_IDX]);

   assert_master_gate_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !p_master |-> !cpu_irq_o);
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
   localparam int NS = 16;
   localparam int NP = 8;
   localparam int CASC = 3;
   localparam int MIDX = 31;
   localparam logic [3:0] A_PID = 4'h0, A_PEN = 4'h4, A_SID = 4'h8, A_SEN = 4'hC;

   logic clk = 1'b0;
   logic rst;
   logic [NS-1:0] sec_evt;
   logic [NP-1:0] pri_evt;
   logic reg_wr, reg_rd;
   logic [3:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic cpu_irq;

   always #2 clk = ~clk;

   irq_cascade_ctrl #(.NUM_SEC(NS), .NUM_PRI(NP), .CASCADE_IDX(CASC), .MASTER_IDX(MIDX)) dut (
      .clk_i(clk), .rst_i(rst), .sec_evt_i(sec_evt), .pri_evt_i(pri_evt),
      .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cpu_irq_o(cpu_irq)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [NS-1:0] mv_s, mq_s, m_sen;
   logic [NP-1:0] mv_p, mq_p, m_pen;
   logic m_master, m_prev;

   function automatic logic [1:0] slot_model(input logic v, input logic q,
                                             input logic e, input logic c);
      if (v && c) return {e, q};
      if (v)      return {1'b1, q | e};
      if (q)      return {1'b1, e};
      return {e, 1'b0};
   endfunction

   function automatic logic model_irq();
      return m_master & (|((mv_p | mq_p) & m_pen));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [NS-1:0] sev, input logic [NP-1:0] pev,
                       input logic wr, input logic rd,
                       input logic [3:0] addr, input logic [31:0] wd);
      logic [31:0] exp_rd;
      logic [NS-1:0] nv_s, nq_s, sclr;
      logic [NP-1:0] nv_p, nq_p, pclr, pe;
      logic sum, rise;
      @(negedge clk);
      sec_evt = sev; pri_evt = pev; reg_wr = wr; reg_rd = rd;
      reg_addr = addr; reg_wdata = wd;
      case (addr[3:2])
         2'd0: exp_rd = 32'(mv_p);
         2'd1: exp_rd = 32'(m_pen) | (32'(m_master) << MIDX);
         2'd2: exp_rd = 32'(mv_s);
         default: exp_rd = 32'(m_sen);
      endcase
      sclr = (wr && addr[3:2] == 2'd2) ? wd[NS-1:0] : '0;
      pclr = (wr && addr[3:2] == 2'd0) ? wd[NP-1:0] : '0;
      sum  = |((mv_s | mq_s) & m_sen);
      rise = sum & ~m_prev;
      pe   = pev | (NP'(rise) << CASC);
      for (int i = 0; i < NS; i++) {nv_s[i], nq_s[i]} = slot_model(mv_s[i], mq_s[i], sev[i], sclr[i]);
      for (int i = 0; i < NP; i++) {nv_p[i], nq_p[i]} = slot_model(mv_p[i], mq_p[i], pe[i], pclr[i]);
      @(posedge clk);
      #1;
      mv_s = nv_s; mq_s = nq_s; mv_p = nv_p; mq_p = nq_p; m_prev = sum;
      if (wr && addr[3:2] == 2'd1) begin m_pen = wd[NP-1:0]; m_master = wd[MIDX]; end
      if (wr && addr[3:2] == 2'd3) m_sen = wd[NS-1:0];
      if (rd) chk("R11 model read", reg_rdata, exp_rd);
      chk("R10 model irq", 32'(cpu_irq), 32'(model_irq()));
   endtask

   task automatic idle(); step('0, '0, 1'b0, 1'b0, 4'h0, 32'h0); endtask
   task automatic wreg(input logic [3:0] a, input logic [31:0] d); step('0, '0, 1'b1, 1'b0, a, d); endtask
   task automatic rreg(input logic [3:0] a, output logic [31:0] v);
      step('0, '0, 1'b0, 1'b1, a, 32'h0);
      v = reg_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5eed_0042));
      rst = 1'b1; sec_evt = '0; pri_evt = '0; reg_wr = 0; reg_rd = 0;
      reg_addr = '0; reg_wdata = '0;
      mv_s = '0; mq_s = '0; m_sen = '0; mv_p = '0; mq_p = '0; m_pen = '0;
      m_master = 0; m_prev = 0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1 reset state
      rreg(A_PID, v); chk("R1 pid", v, 0);
      rreg(A_PEN, v); chk("R1 pen", v, 0);
      rreg(A_SID, v); chk("R1 sid", v, 0);
      rreg(A_SEN, v); chk("R1 sen", v, 0);
      chk("R1 irq", 32'(cpu_irq), 0);

      // R2 masked event still recorded, no cascade
      step(NS'(1 << 2), '0, 0, 0, 4'h0, 0);
      rreg(A_SID, v); chk("R2 masked record", v, 32'h4);
      rreg(A_PID, v); chk("R2 no cascade when masked", v, 0);

      // R3/R4 queue, drop, refill gap
      step(NS'(1 << 2), '0, 0, 0, 4'h0, 0);
      step(NS'(1 << 2), '0, 0, 0, 4'h0, 0);
      wreg(A_SID, 32'h4);
      rreg(A_SID, v); chk("R4 gap after clear", v, 0);
      rreg(A_SID, v); chk("R4 refill", v, 32'h4);
      wreg(A_SID, 32'h4);
      rreg(A_SID, v); chk("R3 third event dropped a", v, 0);
      rreg(A_SID, v); chk("R3 third event dropped b", v, 0);

      // R5 clear and event together
      step(NS'(1 << 5), '0, 0, 0, 4'h0, 0);
      step(NS'(1 << 5), '0, 1, 0, A_SID, 32'h20);
      rreg(A_SID, v); chk("R5 stays set", v, 32'h20);
      wreg(A_SID, 32'h20);
      rreg(A_SID, v); chk("R5 nothing queued a", v, 0);
      rreg(A_SID, v); chk("R5 nothing queued b", v, 0);

      // R6 cascade one edge after summary rises
      wreg(A_PEN, (32'h1 << MIDX) | (32'h1 << CASC));
      wreg(A_SEN, 32'h2);
      step(NS'(1 << 1), '0, 0, 0, 4'h0, 0);
      rreg(A_PID, v); chk("R6 not yet cascaded", v, 0);
      rreg(A_PID, v); chk("R6 cascade set", v, 32'h1 << CASC);
      chk("R10 irq on", 32'(cpu_irq), 1);

      // R7 summary held high: no re-signal
      wreg(A_PID, 32'h1 << CASC);
      step(NS'(1 << 1), '0, 0, 0, 4'h0, 0);
      step(NS'(1 << 4), '0, 0, 0, 4'h0, 0);
      rreg(A_PID, v); chk("R7 no re-cascade a", v, 0);
      rreg(A_PID, v); chk("R7 no re-cascade b", v, 0);
      chk("R7 irq low", 32'(cpu_irq), 0);

      // R8 enable toggle re-signals
      wreg(A_SEN, 32'h0);
      idle();
      wreg(A_SEN, 32'h2);
      rreg(A_PID, v); chk("R8 before rise edge", v, 0);
      rreg(A_PID, v); chk("R8 cascade after restore", v, 32'h1 << CASC);

      // R9 master gate, R10 enable gate
      wreg(A_PEN, 32'h1 << CASC);
      chk("R9 master clear", 32'(cpu_irq), 0);
      rreg(A_PEN, v); chk("R11 pen readback", v, 32'h1 << CASC);
      wreg(A_PEN, (32'h1 << MIDX) | (32'h1 << CASC));
      chk("R10 master set", 32'(cpu_irq), 1);
      wreg(A_PEN, 32'h1 << MIDX);
      chk("R10 bit disabled", 32'(cpu_irq), 0);

      // R12 primary queueing
      step('0, NP'(1), 0, 0, 4'h0, 0);
      step('0, NP'(1), 0, 0, 4'h0, 0);
      rreg(A_PID, v); chk("R12 primary set", v, 32'h9);
      wreg(A_PID, 32'h1);
      rreg(A_PID, v); chk("R12 primary gap", v, 32'h8);
      rreg(A_PID, v); chk("R12 primary refill", v, 32'h9);
      wreg(A_PEN, (32'h1 << MIDX) | 32'h1);
      chk("R10 primary source irq", 32'(cpu_irq), 1);

      // constrained random phase against model
      for (int n = 0; n < 6000; n++) begin
         logic [NS-1:0] se;
         logic [NP-1:0] pe;
         logic w, r;
         logic [3:0] a;
         se = NS'($urandom & $urandom & $urandom);
         pe = NP'($urandom & $urandom & $urandom);
         w  = ($urandom % 6) == 0;
         r  = ($urandom % 2) == 0;
         a  = {2'($urandom % 4), 2'b00};
         step(se, pe, w, r, a, $urandom);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule